// File: doc/BRIEF.md
# Lane-Stratified Reorder Buffer

This block is a circular reorder buffer of 32 slots. Each slot belongs to one of four destination-register lanes. The lane is the low two bits of the slot index, and a slot only accepts an instruction whose destination register has the same low two bits. An incoming instruction takes the first slot of its own lane at or after the tail. Any slots passed over on the way are marked as skipped and stay empty. Execution units report results against a slot index. The buffer hands results to the register file strictly in allocation order, at most one per cycle, and steps past skipped slots as it goes.

A source-operand lookup checks only the slots of the lane named by the source register's low bits. Within those slots it compares a short tag that holds the upper register bits. It reports whether an in-flight producer exists, which slot holds the youngest such producer, whether that result is already available, and the result value. A synchronous flush empties the whole buffer.

Top module: `rob_lane_strat`

## Requirements
- R1: After reset, no retirement is reported, no lookup hits, and an instruction with destination lane 0 is offered slot 0.
- R2: An accepted instruction occupies a slot whose index bits [1:0] equal its destination register bits [1:0]. The slot is the first such slot at or after the tail.
- R3: Slots passed over during allocation stay empty. They never retire a value and never answer a lookup, and the tail moves one past the occupied slot.
- R4: When every instruction targets the same lane, exactly 8 are accepted into an empty buffer before it reports not ready.
- R5: alloc_ready_o is low when the skipped slots plus the target slot would exceed the free space. A request offered while not ready changes nothing.
- R6: A completion to an issued slot stores its data. The instruction later retires with its slot index, its full destination register number and that data.
- R7: A completion that names a slot which is not in the issued state is ignored, and the slot does not become done.
- R8: Retirement is in allocation order and commits at most one instruction per cycle. A done instruction behind an issued one waits. Up to 3 skipped slots in front of a done one are passed over in the same cycle.
- R9: A lookup returns hit for the youngest issued or done slot in the source's lane whose tag equals source bits [4:2]. It also returns that slot, its done flag and, when done, its data.
- R10: A lookup reports no hit when no live slot in the lane matches the tag, including after the producer has retired.
- R11: A flush empties every slot and resets both pointers. In the next cycle nothing retires, no lookup hits, and lane 0 is offered slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of all slots |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_dst_i | input | 5 | Destination register of the new instruction |
| alloc_ready_o | output | 1 | Allocation can be accepted this cycle |
| alloc_slot_o | output | 5 | Slot the request would occupy |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_slot_i | input | 5 | Slot being completed |
| cmpl_data_i | input | 32 | Result value |
| retire_valid_o | output | 1 | One instruction retires this cycle |
| retire_slot_o | output | 5 | Slot being retired |
| retire_dst_o | output | 5 | Destination register being written |
| retire_data_o | output | 32 | Value being written |
| lookup_src_i | input | 5 | Source register queried |
| lookup_hit_o | output | 1 | An in-flight producer exists |
| lookup_done_o | output | 1 | The youngest producer has its result |
| lookup_slot_o | output | 5 | Slot of the youngest producer |
| lookup_data_o | output | 32 | Result of that producer when done |

## Verification
The hardest state to reach from the ports is a full buffer whose head window mixes skipped slots with a done entry. A second hard case is an older issued entry that blocks a younger done one. The stimulus builds both on purpose. One sequence places a lane-0 instruction three slots past the tail, so skipped slots sit in front of it, and then completes the younger entries before the older ones. A second sequence fills all 32 slots using a single lane and completes the youngest first. After that, a long random phase with sparse flushes checks every output on every cycle against a behavioural queue model. In that phase, completions land on free and skipped slots as well as issued ones.

// File: rtl/rob_strat_pkg.sv
package rob_strat_pkg;
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_SKIP = 2'd1,
      SLOT_BUSY = 2'd2,
      SLOT_DONE = 2'd3
   } slot_state_e;
endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
   parameter  int SLOTS  = 32,
   parameter  int LANES  = 4,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int PTR_W  = IDX_W + 1,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [PTR_W-1:0]  tail_i,
   input  logic [PTR_W-1:0]  occ_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic              target_free_i,
   output logic [LANE_W-1:0] skip_o,
   output logic [IDX_W-1:0]  target_o,
   output logic              ready_o
);
   logic [PTR_W:0] need;
   logic           room;

   // distance from the tail to the first slot of the requested lane
   assign skip_o   = lane_i - tail_i[LANE_W-1:0];
   assign target_o = tail_i[IDX_W-1:0] + IDX_W'(skip_o);

   always_comb begin
      need = {1'b0, occ_i} + (PTR_W+1)'(skip_o) + (PTR_W+1)'(1);
      room = need <= (PTR_W+1)'(SLOTS);
   end

   assign ready_o = room && target_free_i;
endmodule

// File: rtl/rob_retire_scan.sv
module rob_retire_scan
   import rob_strat_pkg::*;
#(
   parameter  int SLOTS  = 32,
   parameter  int LANES  = 4,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int PTR_W  = IDX_W + 1,
   localparam int LANE_W = $clog2(LANES)
) (
   input  slot_state_e       st_i [SLOTS],
   input  logic [IDX_W-1:0]  head_i,
   input  logic [PTR_W-1:0]  occ_i,
   output logic [LANE_W:0]   adv_o,
   output logic              commit_o,
   output logic [IDX_W-1:0]  commit_idx_o
);
   logic             stop;
   logic [IDX_W-1:0] idx;

   // window of LANES slots from the head: leading skips drain, first real entry decides
   always_comb begin
      adv_o        = '0;
      commit_o     = 1'b0;
      commit_idx_o = head_i;
      stop         = 1'b0;
      idx          = head_i;
      for (int k = 0; k < LANES; k++) begin
         idx = head_i + IDX_W'(k);
         if (!stop && (PTR_W'(k) < occ_i)) begin
            if (st_i[idx] == SLOT_SKIP) begin
               adv_o = (LANE_W+1)'(k + 1);
            end else begin
               stop = 1'b1;
               if (st_i[idx] == SLOT_DONE) begin
                  commit_o     = 1'b1;
                  commit_idx_o = idx;
                  adv_o        = (LANE_W+1)'(k + 1);
               end
            end
         end else begin
            stop = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rob_lane_cam.sv
module rob_lane_cam
   import rob_strat_pkg::*;
#(
   parameter  int SLOTS  = 32,
   parameter  int LANES  = 4,
   parameter  int REG_W  = 5,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int LANE_W = $clog2(LANES),
   localparam int TAG_W  = REG_W - LANE_W,
   localparam int ROWS   = SLOTS / LANES
) (
   input  slot_state_e       st_i  [SLOTS],
   input  logic [TAG_W-1:0]  tag_i [SLOTS],
   input  logic [IDX_W-1:0]  head_i,
   input  logic [REG_W-1:0]  src_i,
   output logic              hit_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  idx_o
);
   logic [IDX_W-1:0] s;
   logic [IDX_W-1:0] age;
   logic [IDX_W-1:0] best_age;

   // only the ROWS slots of the source lane are compared; the newest (largest age) wins
   always_comb begin
      hit_o    = 1'b0;
      done_o   = 1'b0;
      idx_o    = '0;
      best_age = '0;
      s        = '0;
      age      = '0;
      for (int j = 0; j < ROWS; j++) begin
         s   = IDX_W'(j * LANES) | IDX_W'(src_i[LANE_W-1:0]);
         age = s - head_i;
         if ((st_i[s] == SLOT_BUSY || st_i[s] == SLOT_DONE) &&
             tag_i[s] == src_i[REG_W-1:LANE_W] &&
             (!hit_o || age > best_age)) begin
            hit_o    = 1'b1;
            best_age = age;
            idx_o    = s;
            done_o   = st_i[s] == SLOT_DONE;
         end
      end
   end
endmodule

// File: rtl/rob_lane_strat.sv
module rob_lane_strat
   import rob_strat_pkg::*;
#(
   parameter  int SLOTS  = 32,
   parameter  int LANES  = 4,
   parameter  int REG_W  = 5,
   parameter  int DATA_W = 32,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int PTR_W  = IDX_W + 1,
   localparam int LANE_W = $clog2(LANES),
   localparam int TAG_W  = REG_W - LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              alloc_valid_i,
   input  logic [REG_W-1:0]  alloc_dst_i,
   output logic              alloc_ready_o,
   output logic [IDX_W-1:0]  alloc_slot_o,
   input  logic              cmpl_valid_i,
   input  logic [IDX_W-1:0]  cmpl_slot_i,
   input  logic [DATA_W-1:0] cmpl_data_i,
   output logic              retire_valid_o,
   output logic [IDX_W-1:0]  retire_slot_o,
   output logic [REG_W-1:0]  retire_dst_o,
   output logic [DATA_W-1:0] retire_data_o,
   input  logic [REG_W-1:0]  lookup_src_i,
   output logic              lookup_hit_o,
   output logic              lookup_done_o,
   output logic [IDX_W-1:0]  lookup_slot_o,
   output logic [DATA_W-1:0] lookup_data_o
);
   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if ((SLOTS & (SLOTS - 1)) != 0 || SLOTS < 2 * LANES) begin : g_bad_slots
      $error("SLOTS must be a power of two holding at least two rows of lanes");
   end
   if (REG_W <= LANE_W) begin : g_bad_regw
      $error("REG_W must exceed the lane field width");
   end

   logic [PTR_W-1:0]  head_q, tail_q, occ;
   slot_state_e       st_arr   [SLOTS];
   logic [TAG_W-1:0]  tag_arr  [SLOTS];
   logic [DATA_W-1:0] data_arr [SLOTS];

   logic [LANE_W-1:0] skip;
   logic [IDX_W-1:0]  target;
   logic              alloc_fire;
   logic [LANE_W:0]   ret_adv;
   logic              commit;
   logic [IDX_W-1:0]  commit_idx;

   assign occ = tail_q - head_q;

   rob_alloc_ctrl #(.SLOTS(SLOTS), .LANES(LANES)) u_alloc (
      .tail_i        (tail_q),
      .occ_i         (occ),
      .lane_i        (alloc_dst_i[LANE_W-1:0]),
      .target_free_i (st_arr[target] == SLOT_FREE),
      .skip_o        (skip),
      .target_o      (target),
      .ready_o       (alloc_ready_o)
   );

   assign alloc_slot_o = target;
   assign alloc_fire   = alloc_valid_i && alloc_ready_o && !flush_i;

   rob_retire_scan #(.SLOTS(SLOTS), .LANES(LANES)) u_retire (
      .st_i         (st_arr),
      .head_i       (head_q[IDX_W-1:0]),
      .occ_i        (occ),
      .adv_o        (ret_adv),
      .commit_o     (commit),
      .commit_idx_o (commit_idx)
   );

   rob_lane_cam #(.SLOTS(SLOTS), .LANES(LANES), .REG_W(REG_W)) u_cam (
      .st_i   (st_arr),
      .tag_i  (tag_arr),
      .head_i (head_q[IDX_W-1:0]),
      .src_i  (lookup_src_i),
      .hit_o  (lookup_hit_o),
      .done_o (lookup_done_o),
      .idx_o  (lookup_slot_o)
   );

   // per-slot state, tag and result storage
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      slot_state_e       st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic [IDX_W-1:0]  from_tail, from_head;

      assign from_tail = IDX_W'(i) - tail_q[IDX_W-1:0];
      assign from_head = IDX_W'(i) - head_q[IDX_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= SLOT_FREE;
            tag_q  <= '0;
            data_q <= '0;
         end else if (flush_i) begin
            st_q   <= SLOT_FREE;
         end else if (alloc_fire && from_tail < IDX_W'(skip)) begin
            st_q   <= SLOT_SKIP;
         end else if (alloc_fire && IDX_W'(i) == target) begin
            st_q   <= SLOT_BUSY;
            tag_q  <= alloc_dst_i[REG_W-1:LANE_W];
         end else if (cmpl_valid_i && cmpl_slot_i == IDX_W'(i) && st_q == SLOT_BUSY) begin
            st_q   <= SLOT_DONE;
            data_q <= cmpl_data_i;
         end else if (from_head < IDX_W'(ret_adv)) begin
            st_q   <= SLOT_FREE;
         end
      end

      assign st_arr[i]   = st_q;
      assign tag_arr[i]  = tag_q;
      assign data_arr[i] = data_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (flush_i) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (alloc_fire) tail_q <= tail_q + PTR_W'(skip) + PTR_W'(1);
         head_q <= head_q + PTR_W'(ret_adv);
      end
   end

   assign retire_valid_o = commit && !flush_i;
   assign retire_slot_o  = commit_idx;
   assign retire_dst_o   = {tag_arr[commit_idx], commit_idx[LANE_W-1:0]};
   assign retire_data_o  = data_arr[commit_idx];
   assign lookup_data_o  = data_arr[lookup_slot_o];
endmodule

// File: rtl/rob_lane_strat_chk.sv
module rob_lane_strat_chk #(
   parameter  int SLOTS  = 32,
   parameter  int LANES  = 4,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int PTR_W  = IDX_W + 1,
   localparam int LANE_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              alloc_valid_i,
   input logic              alloc_ready_o,
   input logic [LANE_W-1:0] dst_lane,
   input logic [LANE_W-1:0] slot_lane,
   input logic              retire_valid_o,
   input logic              lookup_hit_o,
   input logic              lookup_done_o,
   input logic [PTR_W-1:0]  head_q,
   input logic [PTR_W-1:0]  tail_q
);
   AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid_i && alloc_ready_o |-> slot_lane == dst_lane);                   // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      PTR_W'(tail_q - head_q) <= PTR_W'(SLOTS));                                   // R5

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid_i && !alloc_ready_o && !flush_i |=> tail_q == $past(tail_q));   // R5

   AST_RETIRE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid_o |=> head_q != $past(head_q));                                 // R6

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !retire_valid_o && !lookup_hit_o);                               // R11

   AST_DONE_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_done_o |-> lookup_hit_o);                                             // R9
endmodule

bind rob_lane_strat rob_lane_strat_chk #(.SLOTS(SLOTS), .LANES(LANES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .flush_i        (flush_i),
   .alloc_valid_i  (alloc_valid_i),
   .alloc_ready_o  (alloc_ready_o),
   .dst_lane       (alloc_dst_i[LANE_W-1:0]),
   .slot_lane      (alloc_slot_o[LANE_W-1:0]),
   .retire_valid_o (retire_valid_o),
   .lookup_hit_o   (lookup_hit_o),
   .lookup_done_o  (lookup_done_o),
   .head_q         (head_q),
   .tail_q         (tail_q)
);

// File: tb/sim_rob_lane_strat.sv
`timescale 1ns/100ps
module sim_rob_lane_strat;
   localparam int SLOTS = 32;
   localparam int LANES = 4;
   localparam int ST_FREE = 0, ST_SKIP = 1, ST_BUSY = 2, ST_DONE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        alloc_valid = 1'b0;
   logic [4:0]  alloc_dst = '0;
   logic        alloc_ready;
   logic [4:0]  alloc_slot;
   logic        cmpl_valid = 1'b0;
   logic [4:0]  cmpl_slot = '0;
   logic [31:0] cmpl_data = '0;
   logic        retire_valid;
   logic [4:0]  retire_slot, retire_dst;
   logic [31:0] retire_data;
   logic [4:0]  lookup_src = '0;
   logic        lookup_hit, lookup_done;
   logic [4:0]  lookup_slot;
   logic [31:0] lookup_data;

   always #2 clk = ~clk;

   rob_lane_strat u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .alloc_valid_i(alloc_valid), .alloc_dst_i(alloc_dst),
      .alloc_ready_o(alloc_ready), .alloc_slot_o(alloc_slot),
      .cmpl_valid_i(cmpl_valid), .cmpl_slot_i(cmpl_slot), .cmpl_data_i(cmpl_data),
      .retire_valid_o(retire_valid), .retire_slot_o(retire_slot),
      .retire_dst_o(retire_dst), .retire_data_o(retire_data),
      .lookup_src_i(lookup_src), .lookup_hit_o(lookup_hit),
      .lookup_done_o(lookup_done), .lookup_slot_o(lookup_slot),
      .lookup_data_o(lookup_data)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   int          m_st   [SLOTS];
   int          m_dst  [SLOTS];
   logic [31:0] m_data [SLOTS];
   int          m_head = 0;
   int          m_tail = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      flush = 1'b0; alloc_valid = 1'b0; cmpl_valid = 1'b0;
   endtask

   // one clock: compare every output against the queue model, then advance the model
   task automatic step();
      int occ, skip, tslot, adv, cidx, lslot;
      bit rdy, commit, lhit, ldone;
      #0.5;
      occ   = m_tail - m_head;
      skip  = (int'(alloc_dst) % LANES - m_tail % LANES + LANES) % LANES;
      rdy   = (occ + skip + 1) <= SLOTS;
      tslot = (m_tail + skip) % SLOTS;
      chk("R5", "alloc_ready", alloc_ready, rdy);
      if (rdy) chk("R2", "alloc_slot", alloc_slot, tslot);
      commit = 0; adv = 0; cidx = 0;
      for (int k = 0; k < LANES && k < occ; k++) begin
         int s;
         s = (m_head + k) % SLOTS;
         if (m_st[s] == ST_SKIP) adv = k + 1;
         else begin
            if (m_st[s] == ST_DONE) begin commit = 1; cidx = s; adv = k + 1; end
            break;
         end
      end
      chk("R8", "retire_valid", retire_valid, commit && !flush);
      if (commit && !flush) begin
         chk("R6", "retire_slot", retire_slot, cidx);
         chk("R6", "retire_dst", retire_dst, m_dst[cidx]);
         chk("R6", "retire_data", retire_data, m_data[cidx]);
      end
      lhit = 0; ldone = 0; lslot = 0;
      for (int a = occ - 1; a >= 0; a--) begin
         int s;
         s = (m_head + a) % SLOTS;
         if (s % LANES == int'(lookup_src) % LANES && (m_st[s] == ST_BUSY || m_st[s] == ST_DONE) &&
             m_dst[s] / LANES == int'(lookup_src) / LANES) begin
            lhit = 1; lslot = s; ldone = (m_st[s] == ST_DONE);
            break;
         end
      end
      chk("R9", "lookup_hit", lookup_hit, lhit);
      if (lhit) begin
         chk("R9", "lookup_slot", lookup_slot, lslot);
         chk("R9", "lookup_done", lookup_done, ldone);
         if (ldone) chk("R9", "lookup_data", lookup_data, m_data[lslot]);
      end
      @(posedge clk);
      if (flush) begin
         for (int i = 0; i < SLOTS; i++) m_st[i] = ST_FREE;
         m_head = 0; m_tail = 0;
      end else begin
         if (cmpl_valid && m_st[cmpl_slot] == ST_BUSY) begin
            m_st[cmpl_slot] = ST_DONE; m_data[cmpl_slot] = cmpl_data;
         end
         if (alloc_valid && rdy) begin
            for (int k = 0; k < skip; k++) m_st[(m_tail + k) % SLOTS] = ST_SKIP;
            m_st[tslot] = ST_BUSY; m_dst[tslot] = int'(alloc_dst);
            m_tail += skip + 1;
         end
         for (int k = 0; k < adv; k++) m_st[(m_head + k) % SLOTS] = ST_FREE;
         m_head += adv;
      end
      @(negedge clk);
   endtask

   task automatic alloc(input int dst);
      idle(); alloc_valid = 1'b1; alloc_dst = 5'(dst); step(); idle();
   endtask

   task automatic cmpl(input int slot, input logic [31:0] d);
      idle(); cmpl_valid = 1'b1; cmpl_slot = 5'(slot); cmpl_data = d; step(); idle();
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) begin m_st[i] = ST_FREE; m_dst[i] = 0; m_data[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #0.5;
      chk("R1", "retire_valid after reset", retire_valid, 0);
      chk("R1", "lookup_hit after reset", lookup_hit, 0);
      chk("R1", "alloc_ready after reset", alloc_ready, 1);
      chk("R1", "alloc_slot lane0 after reset", alloc_slot, 0);
      step();

      // skips: dst1 -> slot1 (slot0 skipped), dst2 -> 2, dst7 -> 3, dst4 -> 4
      alloc(1); alloc(2); alloc(7); alloc(4);
      alloc_dst = 5'd8; #0.5;
      chk("R3", "lane0 after tail 5 lands in slot 8", alloc_slot, 8);
      alloc(8);
      // R7: completion to a skipped slot and to a free slot is ignored
      cmpl(5, 32'h5555_0005);
      cmpl(9, 32'hDEAD_0009);
      alloc(1);             // dst1 at tail 9 -> slot 9, younger than slot 1
      lookup_src = 5'd1; #0.5;
      chk("R7", "free-slot completion ignored (done)", lookup_done, 0);
      chk("R9", "youngest producer of r1", lookup_slot, 9);
      step();
      lookup_src = 5'd12; #0.5;
      chk("R10", "no producer for r12", lookup_hit, 0);
      step();
      // R8: younger done waits behind older issued
      lookup_src = 5'd4;
      cmpl(2, 32'hA2A2_0002);
      #0.5; chk("R8", "done slot2 waits for issued slot1", retire_valid, 0);
      cmpl(1, 32'hA1A1_0001);
      #0.5;
      chk("R6", "retire slot1 after skip", retire_slot, 1);
      chk("R6", "retire data slot1", retire_data, 32'hA1A1_0001);
      step();
      #0.5; chk("R6", "retire slot2 next", retire_slot, 2);
      cmpl(4, 32'h4444_0004);
      cmpl(3, 32'h3333_0003);
      cmpl(9, 32'h9999_0009);
      cmpl(8, 32'h8888_0008);
      repeat (6) step();
      lookup_src = 5'd4; #0.5;
      chk("R10", "no hit once r4 producer retired", lookup_hit, 0);
      step();

      // R11 flush, then R4 single-lane fill
      alloc(1);
      flush = 1'b1; step(); idle();
      alloc_dst = 5'd0; lookup_src = 5'd1; #0.5;
      chk("R11", "retire_valid after flush", retire_valid, 0);
      chk("R11", "lookup_hit after flush", lookup_hit, 0);
      chk("R11", "alloc_slot after flush", alloc_slot, 0);
      step();
      begin
         int acc;
         acc = 0;
         for (int n = 0; n < 10; n++) begin
            alloc_dst = 5'd3; #0.5;
            if (alloc_ready) acc++;
            alloc_valid = 1'b1; step(); idle();
         end
         chk("R4", "single-lane instructions accepted", acc, 8);
      end
      alloc_dst = 5'd3; #0.5;
      chk("R5", "not ready when full", alloc_ready, 0);
      step();
      cmpl(31, 32'h3131_0031);
      #0.5; chk("R8", "youngest done cannot retire first", retire_valid, 0);
      cmpl(3, 32'h0303_0003);
      #0.5; chk("R8", "oldest retires with skips", retire_slot, 3);
      step();

      // random phase
      for (int c = 0; c < 4000; c++) begin
         idle();
         flush       = ($urandom % 300) == 0;
         alloc_valid = ($urandom % 2) == 0;
         alloc_dst   = 5'($urandom);
         cmpl_valid  = ($urandom % 3) != 0;
         cmpl_slot   = 5'($urandom);
         cmpl_data   = $urandom;
         lookup_src  = 5'($urandom);
         step();
      end
      idle();
      repeat (2) step();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule